// File: doc/BRIEF.md
# Synchronous Burst Read Clock and Latency Generator

This block runs synchronous burst reads from an external pseudo-static RAM or NOR flash device. It builds the memory clock from the system clock with a programmable divider and selects one of several banks. It holds the address-valid strobe through the first memory clock period. It then counts a programmable number of memory clock periods of initial latency. After that it samples one data word per memory clock rising edge until the requested number of beats has arrived. A wait input from the device pauses sampling on any edge after the latency has run out.

The host starts a burst with a one-cycle request while the block is ready. The request carries the bank, the start address, the burst length as a power of two, a wrap flag, the clock divider field, the latency field and the turnaround field. The block returns one pulse per beat, carrying the sampled word and that beat's address. The beat address either counts upward or wraps inside a window that is aligned to the burst length. After the final beat, chip select releases and a programmable turnaround gap follows. Only then is the block ready again.

Top module: `sync_burst_rd`

## Requirements
- R1: After reset the block is ready, every chip select and the address-valid and output-enable strobes are high (inactive), every memory clock pin is low and no data-valid pulse is given.
- R2: A start request is taken only on a clock edge where ready is high. In the next cycle, the chip select of the requested bank (bank index n drives bit n of the active-low chip select vector) is low and address-valid is low. A start request while ready is low has no effect.
- R3: The memory clock period is div+1 system cycles, and a div field of 0 gives a period of 2. The clock is high for the first floor(period/2) cycles of each period. Its first rising edge comes one system cycle after chip select goes low. Only the selected bank's clock pin toggles, and every clock pin stays low outside a burst.
- R4: Address-valid stays low from chip select assertion until the first falling edge of the memory clock. At that edge it goes high and output enable goes low. Output enable stays low until the burst ends.
- R5: With a latency field lat, the first word is sampled no earlier than rising edge number lat+3, counting the first rising edge as 1. The wait input is ignored on every earlier edge.
- R6: When wait is high at a rising edge from number lat+3 onward, no word is sampled on that edge and the beat count stays unchanged. Sampling is retried on the next rising edge.
- R7: Each sampled word gives exactly one data-valid pulse, one cycle long, in the system cycle after the sampling edge. The pulse carries the data-bus value present at that edge.
- R8: A burst has 2^len beats, and a length field above the configured maximum acts as the maximum. On the edge that samples the last beat, chip select goes high and the memory clock stays low instead of rising.
- R9: Beat b (0-based) from start address A has address A+b when wrap is off. When wrap is on, the upper bits of A above the len lowest bits are kept, and the lowest len bits of A+b are taken.
- R10: Ready returns turn+1 system cycles after chip select goes high.
- R11: The memory address output holds the start address for the whole time chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst request, taken when ready_o is high |
| bank_i | input | BANK_W | Bank to access |
| addr_i | input | ADDR_W | Start address |
| len_lg2_i | input | LG_W | Burst length as log2 of beats |
| wrap_i | input | 1 | Wrap the beat address within an aligned window |
| div_i | input | DIV_W | Memory clock period minus one, in system cycles |
| lat_i | input | LAT_W | Initial latency minus two, in memory clock periods |
| turn_i | input | TURN_W | Turnaround length minus one, in system cycles |
| ready_o | output | 1 | Idle and able to take a request |
| rd_valid_o | output | 1 | One pulse per sampled beat |
| rd_data_o | output | DATA_W | Sampled word |
| rd_addr_o | output | ADDR_W | Address of the sampled beat |
| mem_clk_o | output | NUM_BANKS | Memory clock, one pin per bank |
| mem_cs_n_o | output | NUM_BANKS | Active-low chip select, one per bank |
| mem_adv_n_o | output | 1 | Active-low address-valid strobe |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_addr_o | output | ADDR_W | Address bus toward the device |
| mem_wait_i | input | 1 | Device wait, active high |
| mem_dq_i | input | DATA_W | Device data bus |

## Verification
Count k in system cycles after the edge that takes a request, and let P be the clock period. Then chip select and address-valid are due at k=0, rising edge n falls at k=1+(n-1)P, and address-valid lifts at k=1+floor(P/2). A word sampled at edge n shows on data-valid at k=1+(n-1)P, and ready returns at the last sampling k plus turn+1. The bench's reference model builds these instants for each burst from its own list of wait edges and compares every output on the falling clock edge, half a cycle after each register has updated. The bursts cover odd and even periods, the clamped divider, maximum latency, a single beat, wrapped and linear addresses, waits both before and after the latency, an oversize length field, and a request made while busy.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_TURN = 2'd2
   } sbr_state_e;

endpackage

// File: rtl/sbr_clkdiv.sv
module sbr_clkdiv #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             run_i,
   input  logic             stop_i,
   input  logic [DIV_W-1:0] pm1_i,
   output logic             mclk_o,
   output logic             rise_o,
   output logic             fall_o
);

   logic [DIV_W-1:0] pm1_q;
   logic [DIV_W-1:0] ph_q;
   logic [DIV_W-1:0] ph_nx;
   logic [DIV_W:0]   half;
   logic             mclk_q;

   // high span of the period: floor(period / 2)
   assign half  = ({1'b0, pm1_q} + (DIV_W+1)'(1)) >> 1;
   assign ph_nx = (ph_q == pm1_q) ? '0 : ph_q + DIV_W'(1);

   assign rise_o = run_i && (ph_q == pm1_q);
   assign fall_o = run_i && ({1'b0, ph_nx} == half);
   assign mclk_o = mclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pm1_q  <= DIV_W'(1);
         ph_q   <= '0;
         mclk_q <= 1'b0;
      end else if (load_i) begin
         pm1_q  <= pm1_i;
         ph_q   <= pm1_i;
         mclk_q <= 1'b0;
      end else if (run_i) begin
         if (stop_i) begin
            ph_q   <= pm1_q;
            mclk_q <= 1'b0;
         end else begin
            ph_q   <= ph_nx;
            mclk_q <= ({1'b0, ph_nx} < half);
         end
      end else begin
         mclk_q <= 1'b0;
      end
   end

endmodule

// File: rtl/sbr_beat_seq.sv
module sbr_beat_seq #(
   parameter int ADDR_W  = 24,
   parameter int LAT_W   = 4,
   parameter int LG_W    = 3,
   parameter int BCNT_W  = 5,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [LG_W-1:0]   lg2_i,
   input  logic              wrap_i,
   input  logic [LAT_W-1:0]  lat_i,
   input  logic              rise_i,
   input  logic              wait_i,
   output logic              cap_o,
   output logic              last_o,
   output logic [ADDR_W-1:0] addr_o
);

   logic [LG_W-1:0]   lg2_q;
   logic              wrap_q;
   logic [LAT_W:0]    lat_q;
   logic [LAT_W:0]    ecnt_q;
   logic [BCNT_W-1:0] bcnt_q;
   logic [BCNT_W-1:0] bm1;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] nxt;
   logic              elig;

   assign elig   = (ecnt_q == lat_q);
   assign cap_o  = rise_i && elig && !wait_i;
   assign bm1    = ~({BCNT_W{1'b1}} << lg2_q);
   assign last_o = cap_o && (bcnt_q == bm1);
   assign addr_o = cur_q;

   generate
      if (WRAP_EN) begin : g_wrap
         logic [ADDR_W-1:0] amask;
         logic [ADDR_W-1:0] inc;
         assign amask = ~({ADDR_W{1'b1}} << lg2_q);
         assign inc   = cur_q + ADDR_W'(1);
         assign nxt   = wrap_q ? ((cur_q & ~amask) | (inc & amask)) : inc;
      end else begin : g_lin
         logic unused_wrap;
         assign unused_wrap = wrap_q;
         assign nxt = cur_q + ADDR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lg2_q  <= '0;
         wrap_q <= 1'b0;
         lat_q  <= '0;
         ecnt_q <= '0;
         bcnt_q <= '0;
         cur_q  <= '0;
      end else if (load_i) begin
         lg2_q  <= lg2_i;
         wrap_q <= wrap_i;
         lat_q  <= {1'b0, lat_i} + (LAT_W+1)'(2);
         ecnt_q <= '0;
         bcnt_q <= '0;
         cur_q  <= base_i;
      end else if (rise_i) begin
         if (!elig) begin
            ecnt_q <= ecnt_q + (LAT_W+1)'(1);
         end else if (cap_o) begin
            bcnt_q <= bcnt_q + BCNT_W'(1);
            cur_q  <= nxt;
         end
      end
   end

endmodule

// File: rtl/sync_burst_rd.sv
module sync_burst_rd
   import sbr_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 16,
   parameter int MAX_LG2   = 4,
   parameter int DIV_W     = 4,
   parameter int LAT_W     = 4,
   parameter int TURN_W    = 4,
   parameter bit WRAP_EN   = 1'b1,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int LG_W     = (MAX_LG2 > 1) ? $clog2(MAX_LG2 + 1) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [BANK_W-1:0]    bank_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [LG_W-1:0]      len_lg2_i,
   input  logic                 wrap_i,
   input  logic [DIV_W-1:0]     div_i,
   input  logic [LAT_W-1:0]     lat_i,
   input  logic [TURN_W-1:0]    turn_i,
   output logic                 ready_o,
   output logic                 rd_valid_o,
   output logic [DATA_W-1:0]    rd_data_o,
   output logic [ADDR_W-1:0]    rd_addr_o,
   output logic [NUM_BANKS-1:0] mem_clk_o,
   output logic [NUM_BANKS-1:0] mem_cs_n_o,
   output logic                 mem_adv_n_o,
   output logic                 mem_oe_n_o,
   output logic [ADDR_W-1:0]    mem_addr_o,
   input  logic                 mem_wait_i,
   input  logic [DATA_W-1:0]    mem_dq_i
);

   localparam int BCNT_W = MAX_LG2 + 1;

   generate
      if (NUM_BANKS < 1)        begin : g_bad_banks $error("NUM_BANKS must be at least 1"); end
      if (MAX_LG2 < 1)          begin : g_bad_len   $error("MAX_LG2 must be at least 1"); end
      if (ADDR_W <= MAX_LG2)    begin : g_bad_addr  $error("ADDR_W must exceed MAX_LG2"); end
      if (DIV_W < 1 || LAT_W < 1 || TURN_W < 1) begin : g_bad_cfg
         $error("configuration field widths must be at least 1");
      end
   endgenerate

   sbr_state_e        st_q;
   logic [BANK_W-1:0] bank_q;
   logic [ADDR_W-1:0] base_q;
   logic [TURN_W-1:0] tcnt_q;
   logic              adv_act_q;
   logic              oe_act_q;
   logic              rd_valid_q;
   logic [DATA_W-1:0] rd_data_q;
   logic [ADDR_W-1:0] rd_addr_q;

   logic              run;
   logic              load;
   logic [LG_W-1:0]   lg2_c;
   logic [DIV_W-1:0]  pm1_in;
   logic              mclk;
   logic              rise;
   logic              fall;
   logic              cap;
   logic              last;
   logic [ADDR_W-1:0] beat_addr;

   assign run     = (st_q == ST_RUN);
   assign ready_o = (st_q == ST_IDLE);
   assign load    = ready_o && start_i;
   assign lg2_c   = (len_lg2_i > LG_W'(MAX_LG2)) ? LG_W'(MAX_LG2) : len_lg2_i;
   assign pm1_in  = (div_i == '0) ? DIV_W'(1) : div_i;

   sbr_clkdiv #(
      .DIV_W (DIV_W)
   ) u_clkdiv (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .run_i  (run),
      .stop_i (last),
      .pm1_i  (pm1_in),
      .mclk_o (mclk),
      .rise_o (rise),
      .fall_o (fall)
   );

   sbr_beat_seq #(
      .ADDR_W  (ADDR_W),
      .LAT_W   (LAT_W),
      .LG_W    (LG_W),
      .BCNT_W  (BCNT_W),
      .WRAP_EN (WRAP_EN)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .base_i (addr_i),
      .lg2_i  (lg2_c),
      .wrap_i (wrap_i),
      .lat_i  (lat_i),
      .rise_i (rise),
      .wait_i (mem_wait_i),
      .cap_o  (cap),
      .last_o (last),
      .addr_o (beat_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         bank_q    <= '0;
         base_q    <= '0;
         tcnt_q    <= '0;
         adv_act_q <= 1'b0;
         oe_act_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q      <= ST_RUN;
                  bank_q    <= bank_i;
                  base_q    <= addr_i;
                  tcnt_q    <= turn_i;
                  adv_act_q <= 1'b1;
                  oe_act_q  <= 1'b0;
               end
            end
            ST_RUN: begin
               if (last) begin
                  st_q      <= ST_TURN;
                  adv_act_q <= 1'b0;
                  oe_act_q  <= 1'b0;
               end else if (fall && adv_act_q) begin
                  adv_act_q <= 1'b0;
                  oe_act_q  <= 1'b1;
               end
            end
            ST_TURN: begin
               if (tcnt_q == '0) st_q <= ST_IDLE;
               else              tcnt_q <= tcnt_q - TURN_W'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
         rd_addr_q  <= '0;
      end else begin
         rd_valid_q <= cap;
         if (cap) begin
            rd_data_q <= mem_dq_i;
            rd_addr_q <= beat_addr;
         end
      end
   end

   generate
      for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
         logic sel;
         assign sel            = run && (bank_q == BANK_W'(gi));
         assign mem_cs_n_o[gi] = ~sel;
         assign mem_clk_o[gi]  = sel && mclk;
      end
   endgenerate

   assign mem_adv_n_o = ~adv_act_q;
   assign mem_oe_n_o  = ~oe_act_q;
   assign mem_addr_o  = base_q;
   assign rd_valid_o  = rd_valid_q;
   assign rd_data_o   = rd_data_q;
   assign rd_addr_o   = rd_addr_q;

endmodule

// File: rtl/sync_burst_rd_chk.sv
module sync_burst_rd_chk #(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 24
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start_i,
   input logic                 ready_o,
   input logic                 rd_valid_o,
   input logic [NUM_BANKS-1:0] mem_clk_o,
   input logic [NUM_BANKS-1:0] mem_cs_n_o,
   input logic                 mem_adv_n_o,
   input logic                 mem_oe_n_o,
   input logic                 mem_wait_i,
   input logic [ADDR_W-1:0]    mem_addr_o
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (mem_clk_o == '0 && (&mem_cs_n_o) && mem_adv_n_o && mem_oe_n_o && !rd_valid_o));

   assert_start_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && start_i) |=> (!(&mem_cs_n_o) && !mem_adv_n_o && mem_clk_o == '0));

   assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_cs_n_o));

   assert_clk_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_clk_o & mem_cs_n_o) == '0);

   assert_adv_oe_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_adv_n_o && !mem_oe_n_o));

   assert_no_wait_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> !$past(mem_wait_i));

   assert_valid_after_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> !$past(mem_oe_n_o));

   assert_valid_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> !ready_o);

   assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&mem_cs_n_o) && !$past(&mem_cs_n_o)) |-> $stable(mem_addr_o));

endmodule

bind sync_burst_rd sync_burst_rd_chk #(
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .ready_o     (ready_o),
   .rd_valid_o  (rd_valid_o),
   .mem_clk_o   (mem_clk_o),
   .mem_cs_n_o  (mem_cs_n_o),
   .mem_adv_n_o (mem_adv_n_o),
   .mem_oe_n_o  (mem_oe_n_o),
   .mem_wait_i  (mem_wait_i),
   .mem_addr_o  (mem_addr_o)
);

// File: tb/sync_burst_rd_tb.sv
module sync_burst_rd_tb;

   localparam int NB  = 4;
   localparam int AW  = 24;
   localparam int DW  = 16;
   localparam int ML  = 4;
   localparam int LGW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    bank = '0;
   logic [AW-1:0] addr = '0;
   logic [LGW-1:0] lg2 = '0;
   logic          wrap = 1'b0;
   logic [3:0]    div = '0;
   logic [3:0]    lat = '0;
   logic [3:0]    turn = '0;
   logic          wt = 1'b0;
   logic [DW-1:0] dq = '0;

   logic          ready, rd_valid, adv_n, oe_n;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] rd_addr, maddr;
   logic [NB-1:0] mclk, cs_n;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   sync_burst_rd #(
      .NUM_BANKS (NB), .ADDR_W (AW), .DATA_W (DW), .MAX_LG2 (ML)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .start_i (start), .bank_i (bank),
      .addr_i (addr), .len_lg2_i (lg2), .wrap_i (wrap), .div_i (div),
      .lat_i (lat), .turn_i (turn), .ready_o (ready), .rd_valid_o (rd_valid),
      .rd_data_o (rd_data), .rd_addr_o (rd_addr), .mem_clk_o (mclk),
      .mem_cs_n_o (cs_n), .mem_adv_n_o (adv_n), .mem_oe_n_o (oe_n),
      .mem_addr_o (maddr), .mem_wait_i (wt), .mem_dq_i (dq)
   );

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, what, $time, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] dat(int id, int k);
      return DW'(id * 97 + k * 13 + 5);
   endfunction

   function automatic logic [AW-1:0] bexp(logic [AW-1:0] base, int b, int lg, bit w);
      logic [AW-1:0] m;
      m = AW'((1 << lg) - 1);
      if (w) return (base & ~m) | ((base + AW'(b)) & m);
      return base + AW'(b);
   endfunction

   // reference model: one burst, compared every cycle at the falling edge
   task automatic run_burst(int b, logic [AW-1:0] base, int lgf, bit w, int dv, int lt,
                            int tn, logic [63:0] wmask, bit poke, int id);
      int p, half, l, t, beats, lge, kend, n, got;
      int cap_k[$];
      p     = (dv == 0) ? 2 : dv + 1;
      half  = p / 2;
      l     = lt + 2;
      t     = tn + 1;
      lge   = (lgf > ML) ? ML : lgf;
      beats = 1 << lge;
      n     = l + 1;
      got   = 0;
      while (got < beats) begin
         if (!wmask[n]) begin
            cap_k.push_back(1 + (n - 1) * p);
            got++;
         end
         n++;
      end
      kend = cap_k[cap_k.size() - 1];

      start = 1'b1; bank = 2'(b); addr = base; lg2 = LGW'(lgf); wrap = w;
      div = 4'(dv); lat = 4'(lt); turn = 4'(tn);
      dq = dat(id, 0); wt = 1'b1;
      @(posedge clk);
      for (int k = 0; k <= kend + t; k++) begin
         logic [NB-1:0] cs_e, clk_e;
         int ci;
         @(negedge clk);
         if (k == 0) start = 1'b0;
         if (poke && k == 2) begin start = 1'b1; bank = 2'((b + 1) % NB); end
         if (poke && k == 3) begin start = 1'b0; bank = 2'(b); end
         cs_e  = '1;
         clk_e = '0;
         if (k < kend) cs_e[b] = 1'b0;
         if (k >= 1 && k < kend && ((k - 1) % p) < half) clk_e[b] = 1'b1;
         ci = -1;
         foreach (cap_k[i]) if (cap_k[i] == k) ci = i;
         check("R2 R8", "cs_n", 64'(cs_n), 64'(cs_e));
         check("R3", "mem_clk", 64'(mclk), 64'(clk_e));
         check("R4", "adv_n", 64'(adv_n), (k < 1 + half) ? 64'd0 : 64'd1);
         check("R4", "oe_n", 64'(oe_n), (k >= 1 + half && k < kend) ? 64'd0 : 64'd1);
         check("R10", "ready", 64'(ready), (k >= kend + t) ? 64'd1 : 64'd0);
         check("R5 R6 R7", "rd_valid", 64'(rd_valid), (ci >= 0) ? 64'd1 : 64'd0);
         if (ci >= 0) begin
            check("R7", "rd_data", 64'(rd_data), 64'(dat(id, k)));
            check("R9", "rd_addr", 64'(rd_addr), 64'(bexp(base, ci, lge, w)));
         end
         if (k < kend) check("R11", "mem_addr", 64'(maddr), 64'(base));
         dq = dat(id, k + 1);
         if ((k % p) == 0 && (k / p + 1) < 64) wt = wmask[k / p + 1];
         else wt = 1'b1;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "ready", 64'(ready), 64'd1);
      check("R1", "cs_n", 64'(cs_n), 64'hF);
      check("R1", "mem_clk", 64'(mclk), 64'd0);
      check("R1", "adv_n", 64'(adv_n), 64'd1);
      check("R1", "oe_n", 64'(oe_n), 64'd1);
      check("R1", "rd_valid", 64'(rd_valid), 64'd0);
      // R2: no request, nothing moves
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R2", "idle cs_n", 64'(cs_n), 64'hF);
      end
      // even period, shortest latency, linear
      run_burst(0, 24'h000100, 2, 1'b0, 1, 0, 0, 64'h0, 1'b0, 1);
      // odd period 3, waits before latency (ignored, R5) and after it (R6), wrap
      run_burst(2, 24'h00003D, 3, 1'b1, 2, 3, 2, 64'h186, 1'b0, 2);
      // divider 0 clamped, maximum latency, request while busy ignored (R2)
      run_burst(1, 24'h000FFF, 1, 1'b1, 0, 15, 15, 64'h0, 1'b1, 3);
      // slowest clock, single beat at top of address space
      run_burst(3, 24'hFFFFFF, 0, 1'b0, 15, 1, 3, 64'h0, 1'b0, 4);
      // period 5, sixteen wrapped beats with scattered waits
      run_burst(0, 24'h001235, 4, 1'b1, 4, 2, 1, 64'h0010_0C40, 1'b0, 5);
      // R8: oversize length field acts as the maximum
      run_burst(2, 24'h000040, 7, 1'b0, 1, 0, 0, 64'h0, 1'b0, 6);
      // R2: after the busy-time request, no extra burst starts
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R2", "no stray burst", 64'(cs_n), 64'hF);
      end
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule